// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block moves outbound packets from memory onto a byte stream by following a linked chain of descriptors. Each descriptor is a 64-byte aligned record in memory holding a link to the next record, the address of a data buffer, a control word and a status word, followed by six per-packet sideband words. The walker reads the descriptor fields through a word-wide memory port that allows one request in flight. It then fetches the buffer one word at a time and presents each word as a stream beat. When the buffer is done, it stamps the descriptor as finished in memory and moves on to the linked record.

A register front end (not part of this block) hands the walker the current and tail pointers and the run and idle flags, and issues a start pulse. The walker returns an updated current pointer after every descriptor, a one-cycle pulse whenever it goes idle, and a one-cycle pulse for every finished frame. Frames may span several descriptors, and the sideband words latched at the first descriptor of a frame stay on a dedicated output. The walk ends after the descriptor sitting at the tail address. It also ends earlier if it meets a descriptor whose status already shows it finished. Only the low 32 bits of each pointer are used.

Top module: `sg_tx_walker`

## Requirements
- R1: After reset there is no memory request and no stream beat, and the pulses `cur_ptr_upd`, `idle_set` and `frame_done` are low.
- R2: A start pulse has no effect unless `run` is 1 and `idle_in` is 0; an ignored start produces no memory request.
- R3: Each descriptor begins with a read of its status word at byte offset 0x1C. If bit 31 of that word is set, the walker pulses `idle_set` and stops, with no stream beat and no memory write.
- R4: The control word at offset 0x18 gives the byte length in bits 22:0, end of frame in bit 26 and start of frame in bit 27. The link is at offset 0x00 and the buffer address is at offset 0x08; only the low words are read.
- R5: The buffer is sent as ceil(length/4) beats of consecutive 32-bit little-endian words, starting at the buffer address. Every beat carries `m_tkeep` = 4'hF, except the final beat of a descriptor whose length is not a multiple of 4. That beat keeps only the low (length mod 4) bytes.
- R6: `m_tlast` is 1 only on the final beat of a descriptor that has the end-of-frame bit set.
- R7: A start-of-frame descriptor loads its six sideband words (offsets 0x20 to 0x34, word k on bits 32k+31:32k) onto `app_words`. A descriptor without that bit leaves `app_words` unchanged.
- R8: After its beats, each descriptor gets a write of (length | 0x8000_0000) to its status word at offset 0x1C.
- R9: When that write completes, `cur_ptr_out` takes the link value and `cur_ptr_upd` pulses for one cycle. `frame_done` pulses in the same cycle if the descriptor had the end-of-frame bit set.
- R10: After the descriptor whose address equals `tail_ptr` has been written back, the walker pulses `idle_set` and reads nothing more.
- R11: `mem_req` stays high with a stable address, direction and write data until `mem_ack`. `m_tvalid` stays high with stable data, keep and last until `m_tready`.
- R12: A zero-length descriptor produces no stream beat but is still written back and still counts for R9 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin walking at `cur_ptr_in` |
| run | input | 1 | Engine enabled |
| idle_in | input | 1 | Engine currently flagged idle |
| cur_ptr_in | input | 32 | Address of the first descriptor to process |
| tail_ptr | input | 32 | Address of the last descriptor to process |
| cur_ptr_out | output | 32 | Link value of the most recently finished descriptor |
| cur_ptr_upd | output | 1 | Pulse: `cur_ptr_out` updated |
| idle_set | output | 1 | Pulse: walk ended, idle should be set |
| frame_done | output | 1 | Pulse: end-of-frame descriptor finished |
| app_words | output | 192 | Sideband words of the current frame |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request completed; read data valid |
| mem_rdata | input | 32 | Memory read data |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Stream beat data |
| m_tkeep | output | 4 | Stream byte enables |
| m_tlast | output | 1 | Final beat of a frame |

## Verification
The bench builds chains in which a frame spans two descriptors with lengths 8 and 5. A walker that drops or miscounts the partial beat would show a wrong `m_tkeep`, or would raise `m_tlast` on the first descriptor of the frame. A descriptor without the start-of-frame bit follows a frame, so a walker that latches sideband words unconditionally ends with the wrong `app_words`. The bench re-runs a chain that has already been written back, to catch a walker that ignores status bit 31 and streams stale data. A zero-length descriptor and a chain that ends on a finished record rather than at the tail test the two stop conditions and the no-beat path; a mishandled length-zero count would wrap and stream millions of beats.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int PTR_W   = 32;
  localparam int LEN_W   = 23;
  localparam int APP_N   = 6;
  localparam int EOF_BIT = 26;
  localparam int SOF_BIT = 27;
  localparam int FIN_BIT = 31;

  localparam logic [PTR_W-1:0] OFS_LINK = 32'h00;
  localparam logic [PTR_W-1:0] OFS_BUF  = 32'h08;
  localparam logic [PTR_W-1:0] OFS_CTL  = 32'h18;
  localparam logic [PTR_W-1:0] OFS_STS  = 32'h1C;
  localparam logic [PTR_W-1:0] OFS_APP  = 32'h20;

  typedef enum logic [3:0] {
    W_IDLE, W_STS, W_CTL, W_LINK, W_BUF, W_APP, W_RD, W_PUSH, W_WB
  } walk_e;

  // Byte enables of a beat given the bytes still left in the buffer.
  function automatic logic [3:0] beat_keep(input logic [31:0] left);
    if (left >= 32'd4) return 4'hF;
    case (left[1:0])
      2'd1:    return 4'h1;
      2'd2:    return 4'h3;
      2'd3:    return 4'h7;
      default: return 4'h0;
    endcase
  endfunction

  // Status word stamped into a finished descriptor.
  function automatic logic [31:0] fin_status(input logic [LEN_W-1:0] len);
    return 32'(len) | (32'd1 << FIN_BIT);
  endfunction
endpackage

// File: rtl/sgw_app_bank.sv
module sgw_app_bank #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   idx,
  input  logic [31:0]     wd,
  output logic [N*32-1:0] words
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic [31:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_q <= '0;
      else if (we && idx == IW'(g)) w_q <= wd;
    end
    assign words[g*32 +: 32] = w_q;
  end
endmodule

// File: rtl/sgw_beat.sv
module sgw_beat
  import sgw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] base,
  input  logic [LEN_W-1:0] len,
  input  logic             eof,
  input  logic             grab,
  input  logic [31:0]      word,
  input  logic             valid,
  input  logic             take,
  output logic [PTR_W-1:0] rd_addr,
  output logic [31:0]      tdata,
  output logic [3:0]       tkeep,
  output logic             tlast,
  output logic             final_beat
);
  logic [PTR_W-1:0] ptr_q;
  logic [LEN_W-1:0] left_q;
  logic [31:0]      data_q;
  logic             eof_q;

  assign final_beat = left_q <= LEN_W'(4);
  assign rd_addr    = ptr_q;
  assign tdata      = data_q;
  assign tkeep      = beat_keep(32'(left_q));
  assign tlast      = eof_q && final_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      left_q <= '0;
      data_q <= '0;
      eof_q  <= 1'b0;
    end else begin
      if (load) begin
        ptr_q  <= base;
        left_q <= len;
        eof_q  <= eof;
      end
      if (grab) data_q <= word;
      if (take) begin
        ptr_q  <= ptr_q + PTR_W'(4);
        left_q <= final_beat ? '0 : left_q - LEN_W'(4);
      end
    end
  end

  // R5
  keep_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> tkeep != 4'h0);
  // R5
  keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !final_beat |-> tkeep == 4'hF && !tlast);
endmodule

// File: rtl/sg_tx_walker.sv
module sg_tx_walker
  import sgw_pkg::*;
#(
  parameter int APP_W = APP_N * 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             idle_in,
  input  logic [31:0]      cur_ptr_in,
  input  logic [31:0]      tail_ptr,
  output logic [31:0]      cur_ptr_out,
  output logic             cur_ptr_upd,
  output logic             idle_set,
  output logic             frame_done,
  output logic [APP_W-1:0] app_words,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic [31:0]      m_tdata,
  output logic [3:0]       m_tkeep,
  output logic             m_tlast
);
  localparam int IW = (APP_N > 1) ? $clog2(APP_N) : 1;

  walk_e            st;
  logic [PTR_W-1:0] desc_q, link_q;
  logic [LEN_W-1:0] len_q;
  logic             sof_q, eof_q;
  logic [IW-1:0]    app_idx;
  logic [PTR_W-1:0] beat_addr;
  logic             final_beat;

  // Named internal events
  logic walk_idle, go, desc_done, at_tail, app_last, beat_load, beat_grab, beat_take;
  assign walk_idle = st == W_IDLE;
  assign go        = walk_idle && start && run && !idle_in;
  assign desc_done = st == W_WB && mem_ack;
  assign at_tail   = desc_q == tail_ptr;
  assign app_last  = app_idx == IW'(APP_N - 1);
  assign beat_load = st == W_BUF && mem_ack;
  assign beat_grab = st == W_RD && mem_ack;
  assign beat_take = m_tvalid && m_tready;

  assign mem_req   = !(st inside {W_IDLE, W_PUSH});
  assign mem_we    = st == W_WB;
  assign mem_wdata = fin_status(len_q);
  assign m_tvalid  = st == W_PUSH;

  always_comb begin
    case (st)
      W_STS:   mem_addr = desc_q + OFS_STS;
      W_CTL:   mem_addr = desc_q + OFS_CTL;
      W_LINK:  mem_addr = desc_q + OFS_LINK;
      W_BUF:   mem_addr = desc_q + OFS_BUF;
      W_APP:   mem_addr = desc_q + OFS_APP + (PTR_W'(app_idx) << 2);
      W_RD:    mem_addr = beat_addr;
      W_WB:    mem_addr = desc_q + OFS_STS;
      default: mem_addr = desc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= W_IDLE;
      desc_q      <= '0;
      link_q      <= '0;
      len_q       <= '0;
      sof_q       <= 1'b0;
      eof_q       <= 1'b0;
      app_idx     <= '0;
      cur_ptr_out <= '0;
      cur_ptr_upd <= 1'b0;
      idle_set    <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      cur_ptr_upd <= 1'b0;
      idle_set    <= 1'b0;
      frame_done  <= 1'b0;
      case (st)
        W_IDLE: if (go) begin
          desc_q <= cur_ptr_in;
          st     <= W_STS;
        end
        W_STS: if (mem_ack) begin
          if (mem_rdata[FIN_BIT]) begin
            idle_set <= 1'b1;
            st       <= W_IDLE;
          end else st <= W_CTL;
        end
        W_CTL: if (mem_ack) begin
          len_q <= mem_rdata[LEN_W-1:0];
          sof_q <= mem_rdata[SOF_BIT];
          eof_q <= mem_rdata[EOF_BIT];
          st    <= W_LINK;
        end
        W_LINK: if (mem_ack) begin
          link_q <= mem_rdata;
          st     <= W_BUF;
        end
        W_BUF: if (mem_ack) begin
          app_idx <= '0;
          if (sof_q)              st <= W_APP;
          else if (len_q == '0)   st <= W_WB;
          else                    st <= W_RD;
        end
        W_APP: if (mem_ack) begin
          if (app_last) st <= (len_q == '0) ? W_WB : W_RD;
          else app_idx <= app_idx + IW'(1);
        end
        W_RD: if (mem_ack) st <= W_PUSH;
        W_PUSH: if (m_tready) st <= final_beat ? W_WB : W_RD;
        W_WB: if (mem_ack) begin
          cur_ptr_out <= link_q;
          cur_ptr_upd <= 1'b1;
          frame_done  <= eof_q;
          if (at_tail) begin
            idle_set <= 1'b1;
            st       <= W_IDLE;
          end else begin
            desc_q <= link_q;
            st     <= W_STS;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  sgw_beat i_beat (
    .clk, .rst_n,
    .load(beat_load), .base(mem_rdata), .len(len_q), .eof(eof_q),
    .grab(beat_grab), .word(mem_rdata),
    .valid(m_tvalid), .take(beat_take),
    .rd_addr(beat_addr), .tdata(m_tdata), .tkeep(m_tkeep), .tlast(m_tlast),
    .final_beat(final_beat)
  );

  sgw_app_bank #(.N(APP_N), .IW(IW)) i_app (
    .clk, .rst_n,
    .we(st == W_APP && mem_ack), .idx(app_idx), .wd(mem_rdata),
    .words(app_words)
  );

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R11
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast));
  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_idle && !(run && !idle_in) |=> !mem_req);
  // R9
  frame_with_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> cur_ptr_upd);
  // R10
  stop_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_set |-> !mem_req && !m_tvalid);
  // R3
  no_write_on_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == W_STS && mem_ack && mem_rdata[FIN_BIT] |=> !mem_req && idle_set);
endmodule

// File: tb/test_sg_tx_walker.sv
module test_sg_tx_walker;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, run = 1'b0, idle_in = 1'b0;
  logic [31:0]  cur_ptr_in = '0, tail_ptr = '0;
  logic [31:0]  cur_ptr_out;
  logic         cur_ptr_upd, idle_set, frame_done;
  logic [191:0] app_words;
  logic         mem_req, mem_we, mem_ack;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata;
  logic         m_tvalid, m_tready, m_tlast;
  logic [31:0]  m_tdata;
  logic [3:0]   m_tkeep;

  always #10 clk = ~clk;  // 50 MHz

  sg_tx_walker i_sg_tx_walker (.*);

  // Memory and its setup path
  logic [31:0] mem [0:1023];
  logic [31:0] img [0:1023];
  logic        pk_en = 1'b0;
  logic [9:0]  pk_idx = '0;
  logic [31:0] pk_val = '0;
  int          lat_cnt;

  initial mem_ack = 1'b0;
  initial mem_rdata = '0;
  initial lat_cnt = 0;
  always @(posedge clk) begin
    if (pk_en) mem[pk_idx] <= pk_val;
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (lat_cnt >= 1) begin
        mem_ack <= 1'b1;
        lat_cnt <= 0;
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[11:2]];
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  // Expected traffic built by the model
  logic [36:0] exp_beat [0:127];
  logic [63:0] exp_wr   [0:127];
  logic [31:0] exp_ptr  [0:127];
  logic [31:0] exp_app  [0:5];
  int exp_beat_n = 0, exp_wr_n = 0, exp_ptr_n = 0, exp_frames = 0, exp_idle = 0;

  int got_beat = 0, got_wr = 0, got_ptr = 0, got_frames = 0, got_idle = 0, req_cycles = 0, cyc = 0;
  int chk_t = 0, fail_t = 0, chk_m = 0, fail_m = 0;

  task automatic tcheck(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    chk_t++;
    if (!ok) begin
      fail_t++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Monitor and stream sink
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_req) req_cycles++;
      if (m_tvalid && m_tready) begin
        chk_m++;
        if (got_beat >= exp_beat_n || {m_tdata, m_tkeep, m_tlast} !== exp_beat[got_beat]) begin
          fail_m++;
          $display("FAIL R5/R6 beat %0d: actual %0h expected %0h", got_beat,
                   {m_tdata, m_tkeep, m_tlast}, exp_beat[got_beat]);
        end
        got_beat++;
      end
      if (mem_ack && mem_we) begin
        chk_m++;
        if (got_wr >= exp_wr_n || {mem_addr, mem_wdata} !== exp_wr[got_wr]) begin
          fail_m++;
          $display("FAIL R8 write %0d: actual %0h expected %0h", got_wr,
                   {mem_addr, mem_wdata}, exp_wr[got_wr]);
        end
        got_wr++;
      end
      if (cur_ptr_upd) begin
        chk_m++;
        if (got_ptr >= exp_ptr_n || cur_ptr_out !== exp_ptr[got_ptr]) begin
          fail_m++;
          $display("FAIL R9 pointer %0d: actual %0h expected %0h", got_ptr, cur_ptr_out, exp_ptr[got_ptr]);
        end
        got_ptr++;
      end
      if (frame_done) got_frames++;
      if (idle_set) got_idle++;
    end
    m_tready <= (cyc % 3) != 1;
  end

  task automatic poke(input int byte_addr, input logic [31:0] v);
    img[byte_addr >> 2] = v;
    @(negedge clk);
    pk_en = 1'b1; pk_idx = 10'(byte_addr >> 2); pk_val = v;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic put_desc(input int a, input int link, input int buff, input logic [31:0] ctl,
                          input logic [31:0] sts, input logic [31:0] app_base);
    poke(a + 'h00, 32'(link));
    poke(a + 'h04, 32'h0);
    poke(a + 'h08, 32'(buff));
    poke(a + 'h0C, 32'h0);
    poke(a + 'h18, ctl);
    poke(a + 'h1C, sts);
    for (int k = 0; k < 6; k++) poke(a + 'h20 + 4*k, app_base + 32'(k));
    for (int w = 0; w < 5; w++) poke(buff + 4*w, 32'h5A00_0000 | 32'(buff + 4*w));
  endtask

  // Behavioural reference of a walk
  task automatic model(input int cur, input int tail);
    int d = cur;
    for (int it = 0; it < 16; it++) begin
      logic [31:0] ctl, lnk, bfa;
      int len;
      if (img[(d + 'h1C) >> 2][31]) begin exp_idle++; return; end
      ctl = img[(d + 'h18) >> 2];
      lnk = img[d >> 2];
      bfa = img[(d + 'h08) >> 2];
      len = int'(ctl[22:0]);
      if (ctl[27]) for (int k = 0; k < 6; k++) exp_app[k] = img[(d + 'h20 + 4*k) >> 2];
      for (int off = 0; off < len; off += 4) begin
        int rem = len - off;
        logic [3:0] kp = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
        exp_beat[exp_beat_n++] = {img[(int'(bfa) + off) >> 2], kp, ctl[26] && rem <= 4};
      end
      exp_wr[exp_wr_n++] = {32'(d + 'h1C), 32'(len) | 32'h8000_0000};
      img[(d + 'h1C) >> 2] = 32'(len) | 32'h8000_0000;
      exp_ptr[exp_ptr_n++] = lnk;
      if (ctl[26]) exp_frames++;
      if (d == tail) begin exp_idle++; return; end
      d = int'(lnk);
    end
  endtask

  task automatic walk(input int cur, input int tail, input string req);
    int wait_n = 0;
    model(cur, tail);
    @(negedge clk);
    cur_ptr_in = 32'(cur); tail_ptr = 32'(tail); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (got_idle < exp_idle && wait_n < 5000) begin @(negedge clk); wait_n++; end
    tcheck(wait_n < 5000, {req, " watchdog"}, 64'(wait_n), 64'd5000);
    repeat (5) @(negedge clk);
    tcheck(got_beat == exp_beat_n, {req, " R5 beat count"}, 64'(got_beat), 64'(exp_beat_n));
    tcheck(got_wr == exp_wr_n, {req, " R8 write count"}, 64'(got_wr), 64'(exp_wr_n));
    tcheck(got_ptr == exp_ptr_n, {req, " R9 update count"}, 64'(got_ptr), 64'(exp_ptr_n));
    tcheck(got_frames == exp_frames, {req, " R9 frames"}, 64'(got_frames), 64'(exp_frames));
    tcheck(got_idle == exp_idle, {req, " R10 idle pulses"}, 64'(got_idle), 64'(exp_idle));
    for (int k = 0; k < 6; k++)
      tcheck(app_words[32*k +: 32] == exp_app[k], {req, " R7 app word"}, 64'(app_words[32*k +: 32]), 64'(exp_app[k]));
  endtask

  initial begin
    int req_before;
    m_tready = 1'b1;
    for (int i = 0; i < 1024; i++) begin img[i] = '0; end
    for (int k = 0; k < 6; k++) exp_app[k] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    tcheck(!mem_req && !m_tvalid, "R1 bus idle", 64'({mem_req, m_tvalid}), 64'd0);
    tcheck(!cur_ptr_upd && !idle_set && !frame_done, "R1 pulses",
           64'({cur_ptr_upd, idle_set, frame_done}), 64'd0);
    rst_n = 1'b1;
    // chain A: frame over two descriptors (8 + 5 bytes), then a non-start EOF descriptor
    put_desc('h000, 'h040, 'h400, 32'h0800_0008, 32'h0, 32'hA000_0000);
    put_desc('h040, 'h080, 'h440, 32'h0400_0005, 32'h0, 32'hB000_0000);
    put_desc('h080, 'h0C0, 'h480, 32'h0400_0003, 32'h0, 32'hC000_0000);
    // R2: start ignored when stopped or idle
    req_before = req_cycles;
    @(negedge clk); run = 1'b0; start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    @(negedge clk); run = 1'b1; idle_in = 1'b1; start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    tcheck(req_cycles == req_before, "R2 no request", 64'(req_cycles), 64'(req_before));
    tcheck(got_ptr == 0 && got_idle == 0, "R2 no pulses", 64'(got_ptr + got_idle), 64'd0);
    idle_in = 1'b0;
    walk('h000, 'h080, "R4 chain A");
    // R3: same chain again, already finished
    walk('h000, 'h080, "R3 finished");
    // chain B: zero length, a 16-byte frame, a 6-byte frame, then a finished record before the tail
    put_desc('h100, 'h140, 'h500, 32'h0C00_0000, 32'h0, 32'hD000_0000);
    put_desc('h140, 'h180, 'h540, 32'h0C00_0010, 32'h0, 32'hE000_0000);
    put_desc('h180, 'h1C0, 'h580, 32'h0C00_0006, 32'h0, 32'hF000_0000);
    put_desc('h1C0, 'h200, 'h5C0, 32'h0C00_0004, 32'h8000_0000, 32'h1000_0000);
    walk('h100, 'h3C0, "R12 chain B");
    $display("End of test - %0d assertions evaluated, %0d failures", chk_t + chk_m, fail_t + fail_m);
    $finish;
  end
endmodule